// File: doc/BRIEF.md
# Power-up wake edge detector

This block watches 32 general-purpose port pins, arranged as four ports of eight pins, plus one USB input, and raises a single wake request when a chosen edge appears on any of them. Each port pin has its own edge-select bit that picks a rising or a falling edge. The USB input has a separate edge-select bit. Every detected edge sets a sticky bit, whether or not that pin is enabled. Software reads the sticky bits to find out which source woke the system. It then writes ones to the bits it has handled. The write is turned into a one-cycle clear pulse.

A per-pin enable register decides which port bits take part in the wake request. A second read view shows only the sticky bits that are also enabled. Writing ones to that view clears only bits that are enabled. All inputs are taken to be synchronous to the block clock. A pin level that is present while reset is held is not counted as an edge.

Top module: `wake_edge_detect`

## Requirements
- R1: After a synchronous reset, every register reads zero and `wake_req` is low.
- R2: Edge-select register (0x704) bit n configures port pin n: 0 latches a rising edge and 1 latches a falling edge; the opposite edge sets nothing.
- R3: The port source register (0x718) returns the sticky bits with bit n = port p pin b where n = 8*p + b, and a bit is latched whether or not its enable bit is set.
- R4: Writing to 0x718 clears every bit written as 1, any number at once, through a pulse that takes effect one cycle after the write; bits written as 0 are unchanged.
- R5: The masked view (0x720) reads the sticky bits ANDed with the enable register (0x710); writing ones there clears only bits that are also enabled.
- R6: `wake_req` is high exactly when an enabled port sticky bit or the USB sticky bit is set.
- R7: The USB input has its own edge-select (0x708 bit 0, 0 rising, 1 falling) and its own sticky bit (0x71C bit 0, write 1 to clear), independent of the port path.
- R8: An edge that arrives in the same cycle as the clear pulse for its bit wins, and the bit stays set.
- R9: The configuration registers at 0x704, 0x708 and 0x710 read back their written values; all other addresses read zero.
- R10: Pin levels held while reset is asserted produce no sticky bit when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| port_pins | input | 32 | Port pins, 8 per port, port 0 in the low byte |
| usb_pin | input | 1 | USB wake input |
| wake_req | output | 1 | Combined wake request |

## Verification
The bench sweeps every port pin under both edge polarities. It checks that only the selected edge sets the pin's own bit. A design with inverted polarity, or one that latches both edges, fails on the return stroke. A clear that fires in the same cycle as a fresh edge must leave the bit set, so a design that gives the clear priority loses the edge. A masked-view write that reaches disabled bits, or a sticky bit that ignores disabled pins, shows up as a wrong source read-back. A pin already high when reset is released must not create a bit, which catches an edge detector whose history register is not loaded during reset.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // register offsets decoded by the bus
    localparam addr_t OFS_EDGE_SEL  = 12'h704;
    localparam addr_t OFS_USB_EDGE  = 12'h708;
    localparam addr_t OFS_PIN_EN    = 12'h710;
    localparam addr_t OFS_SRC       = 12'h718;
    localparam addr_t OFS_USB_SRC   = 12'h71C;
    localparam addr_t OFS_MASKED    = 12'h720;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic  wr;
        addr_t addr;
        data_t wdata;
    } bus_req_t;

    // true when the sampled transition matches the selected edge
    function automatic logic edge_hit(logic prev, logic cur, edge_kind_e kind);
        logic hit;
        if (kind == EDGE_RISE) hit = !prev && cur;
        else                   hit = prev && !cur;
        return hit;
    endfunction

endpackage

// File: rtl/wake_edge_latch.sv
module wake_edge_latch #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] clr,
    output logic [W-1:0] latched
);
    import wake_pkg::*;

    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    // history is loaded during reset too, so a static level is never an edge
    always_ff @(posedge clk) begin
        prev_q <= pin;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign hit[g] = edge_hit(prev_q[g], pin[g], edge_kind_e'(edge_sel[g]));
    end

    // a new edge outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) latched <= '0;
        else     latched <= (latched & ~clr) | hit;
    end

endmodule

// File: rtl/wake_clr_pulse.sv
module wake_clr_pulse #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req,
    output logic [W-1:0] pulse
);
    // one registered stage: each write yields a single-cycle pulse
    always_ff @(posedge clk) begin
        if (rst) pulse <= '0;
        else     pulse <= req;
    end

endmodule

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs #(
    parameter int PIN_CNT = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wake_pkg::bus_req_t     req,
    input  logic [PIN_CNT-1:0]     port_latched,
    input  logic                   usb_latched,
    output logic [PIN_CNT-1:0]     edge_sel,
    output logic                   usb_edge,
    output logic [PIN_CNT-1:0]     enable,
    output logic [PIN_CNT-1:0]     port_clr_req,
    output logic                   usb_clr_req,
    output wake_pkg::data_t        rdata
);
    import wake_pkg::*;

    logic [PIN_CNT-1:0] wpins;
    assign wpins = req.wdata[PIN_CNT-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_sel <= '0;
            usb_edge <= 1'b0;
            enable   <= '0;
        end else if (req.wr) begin
            if (req.addr == OFS_EDGE_SEL) edge_sel <= wpins;
            if (req.addr == OFS_USB_EDGE) usb_edge <= req.wdata[0];
            if (req.addr == OFS_PIN_EN)   enable   <= wpins;
        end
    end

    always_comb begin
        port_clr_req = '0;
        usb_clr_req  = 1'b0;
        if (req.wr) begin
            if (req.addr == OFS_SRC)     port_clr_req = wpins;
            if (req.addr == OFS_MASKED)  port_clr_req = wpins & enable;
            if (req.addr == OFS_USB_SRC) usb_clr_req  = req.wdata[0];
        end
    end

    always_comb begin
        unique case (req.addr)
            OFS_EDGE_SEL: rdata = data_t'(edge_sel);
            OFS_USB_EDGE: rdata = data_t'(usb_edge);
            OFS_PIN_EN:   rdata = data_t'(enable);
            OFS_SRC:      rdata = data_t'(port_latched);
            OFS_USB_SRC:  rdata = data_t'(usb_latched);
            OFS_MASKED:   rdata = data_t'(port_latched & enable);
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/wake_edge_detect.sv
module wake_edge_detect #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_wr_en,
    input  logic [wake_pkg::ADDR_W-1:0]       bus_addr,
    input  logic [wake_pkg::DATA_W-1:0]       bus_wdata,
    output logic [wake_pkg::DATA_W-1:0]       bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0]       port_pins,
    input  logic                              usb_pin,
    output logic                              wake_req
);
    import wake_pkg::*;

    localparam int PIN_CNT = NUM_PORTS * PORT_W;

    bus_req_t           req;
    logic [PIN_CNT-1:0] edge_sel_q;
    logic [PIN_CNT-1:0] enable_q;
    logic               usb_edge_q;
    logic [PIN_CNT-1:0] port_clr_req;
    logic               usb_clr_req;
    logic [PIN_CNT-1:0] port_clr_pulse;
    logic               usb_clr_pulse;
    logic [PIN_CNT-1:0] port_latched;
    logic               usb_latched;

    assign req = '{wr: bus_wr_en, addr: bus_addr, wdata: bus_wdata};

    wake_cfg_regs #(.PIN_CNT(PIN_CNT)) regs_i (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .port_latched (port_latched),
        .usb_latched  (usb_latched),
        .edge_sel     (edge_sel_q),
        .usb_edge     (usb_edge_q),
        .enable       (enable_q),
        .port_clr_req (port_clr_req),
        .usb_clr_req  (usb_clr_req),
        .rdata        (bus_rdata)
    );

    wake_clr_pulse #(.W(PIN_CNT)) port_clr_i (
        .clk   (clk),
        .rst   (rst),
        .req   (port_clr_req),
        .pulse (port_clr_pulse)
    );

    wake_clr_pulse #(.W(1)) usb_clr_i (
        .clk   (clk),
        .rst   (rst),
        .req   (usb_clr_req),
        .pulse (usb_clr_pulse)
    );

    wake_edge_latch #(.W(PIN_CNT)) port_det_i (
        .clk      (clk),
        .rst      (rst),
        .pin      (port_pins),
        .edge_sel (edge_sel_q),
        .clr      (port_clr_pulse),
        .latched  (port_latched)
    );

    wake_edge_latch #(.W(1)) usb_det_i (
        .clk      (clk),
        .rst      (rst),
        .pin      (usb_pin),
        .edge_sel (usb_edge_q),
        .clr      (usb_clr_pulse),
        .latched  (usb_latched)
    );

    assign wake_req = (|(port_latched & enable_q)) | usb_latched;

endmodule

// File: rtl/wake_edge_detect_chk.sv
module wake_edge_detect_chk #(
    parameter int PIN_CNT = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_wr_en,
    input logic [wake_pkg::ADDR_W-1:0] bus_addr,
    input logic [wake_pkg::DATA_W-1:0] bus_rdata,
    input logic [PIN_CNT-1:0]          port_pins,
    input logic                        wake_req,
    input logic [PIN_CNT-1:0]          edge_sel,
    input logic [PIN_CNT-1:0]          port_clr,
    input logic [PIN_CNT-1:0]          port_latched,
    input logic                        usb_clr,
    input logic                        usb_latched
);
    import wake_pkg::*;

    logic [PIN_CNT-1:0] pins_d;
    logic [PIN_CNT-1:0] hits;

    always_ff @(posedge clk) pins_d <= port_pins;

    assign hits = (~edge_sel & ~pins_d & port_pins) | (edge_sel & pins_d & ~port_pins);

    // R2: a matching edge sets its bit on the next edge
    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((port_latched & $past(hits)) == $past(hits)));

    // R2: no bit rises without a matching edge
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((port_latched & ~$past(port_latched) & ~$past(hits)) == '0));

    // R4: a clear pulse drops bits that saw no new edge
    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((port_latched & $past(port_clr & ~hits)) == '0));

    // R4: no clear pulse follows a cycle without a write
    assert_pulse_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> (port_clr == '0 && !usb_clr));

    // R8: an edge meeting a clear pulse keeps its bit
    assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (|(port_clr & hits)) |=> ((port_latched & $past(port_clr & hits)) == $past(port_clr & hits)));

    // R6: a non-zero masked view or USB bit implies a wake request
    assert_masked_wakes_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_MASKED && bus_rdata != '0) |-> wake_req);

    assert_usb_wakes_R6: assert property (@(posedge clk) disable iff (rst)
        usb_latched |-> wake_req);

    // R7: a USB clear pulse without a USB edge empties the USB bit
    assert_usb_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (usb_clr && $stable(usb_latched)) |=> (!usb_latched || $past(usb_latched) == 1'b0));

endmodule

bind wake_edge_detect wake_edge_detect_chk #(.PIN_CNT(NUM_PORTS*PORT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_wr_en    (bus_wr_en),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .port_pins    (port_pins),
    .wake_req     (wake_req),
    .edge_sel     (edge_sel_q),
    .port_clr     (port_clr_pulse),
    .port_latched (port_latched),
    .usb_clr      (usb_clr_pulse),
    .usb_latched  (usb_latched)
);

// File: tb/wake_edge_detect_tb.sv
module wake_edge_detect_tb_top;
    import wake_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] port_pins = 32'hFFFF_0000;
    logic        usb_pin = 1'b0;
    logic        wake_req;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wake_edge_detect dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .port_pins (port_pins),
        .usb_pin   (usb_pin),
        .wake_req  (wake_req)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst = 1'b0;
        repeat (2) tick();

        // R1 and R10: clean state after reset despite high pins
        rd(OFS_SRC, v);      chk("R10 source after reset", v, 32'h0);
        rd(OFS_EDGE_SEL, v); chk("R1 edge select reset", v, 32'h0);
        rd(OFS_PIN_EN, v);   chk("R1 enable reset", v, 32'h0);
        rd(OFS_USB_SRC, v);  chk("R1 usb source reset", v, 32'h0);
        chk("R1 wake low", {31'b0, wake_req}, 32'h0);

        // R9: read-back and unmapped addresses
        wr(OFS_EDGE_SEL, 32'hA5C3_0F81);
        rd(OFS_EDGE_SEL, v); chk("R9 edge readback", v, 32'hA5C3_0F81);
        wr(OFS_USB_EDGE, 32'hFFFF_FFFF);
        rd(OFS_USB_EDGE, v); chk("R9 usb edge readback", v, 32'h1);
        wr(OFS_USB_EDGE, 32'h0);
        rd(12'h714, v);      chk("R9 unmapped reads zero", v, 32'h0);

        // R2/R3/R4/R6: every pin, both polarities
        wr(OFS_PIN_EN, 32'hFFFF_FFFF);
        for (int sel = 0; sel < 2; sel++) begin
            wr(OFS_EDGE_SEL, sel ? 32'hFFFF_FFFF : 32'h0);
            port_pins = sel ? 32'hFFFF_FFFF : 32'h0;
            tick();
            wr(OFS_SRC, 32'hFFFF_FFFF);
            tick();
            rd(OFS_SRC, v); chk("R4 clear all", v, 32'h0);
            for (int i = 0; i < 32; i++) begin
                port_pins[i] = (sel == 0);
                tick();
                rd(OFS_SRC, v); chk("R2 R3 selected edge latched", v, 32'h1 << i);
                chk("R6 wake on enabled bit", {31'b0, wake_req}, 32'h1);
                port_pins[i] = (sel != 0);
                tick();
                rd(OFS_SRC, v); chk("R2 opposite edge ignored", v, 32'h1 << i);
                wr(OFS_SRC, 32'h1 << i);
                tick();
                rd(OFS_SRC, v); chk("R4 single clear", v, 32'h0);
                chk("R6 wake drops", {31'b0, wake_req}, 32'h0);
            end
        end

        // R3/R5/R6: enable gating
        wr(OFS_EDGE_SEL, 32'h0);
        port_pins = 32'h0;
        tick();
        wr(OFS_SRC, 32'hFFFF_FFFF);
        wr(OFS_PIN_EN, 32'h0000_000F);
        port_pins = 32'h0000_0028;
        tick();
        rd(OFS_SRC, v);    chk("R3 latched while disabled", v, 32'h0000_0028);
        rd(OFS_MASKED, v); chk("R5 masked view", v, 32'h0000_0008);
        chk("R6 wake from enabled bit", {31'b0, wake_req}, 32'h1);
        wr(OFS_MASKED, 32'hFFFF_FFFF);
        tick();
        rd(OFS_SRC, v);    chk("R5 masked clear spares disabled", v, 32'h0000_0020);
        chk("R6 disabled bit no wake", {31'b0, wake_req}, 32'h0);
        wr(OFS_PIN_EN, 32'h0000_0020);
        chk("R6 enabling raises wake", {31'b0, wake_req}, 32'h1);

        // R4: multi-bit clear, zeros untouched
        port_pins = 32'h8101_0028 | 32'h0300_0000;
        tick();
        rd(OFS_SRC, v); chk("R3 several bits", v, 32'h8301_0020);
        wr(OFS_SRC, 32'h0);
        tick();
        rd(OFS_SRC, v); chk("R4 zero write no effect", v, 32'h8301_0020);
        wr(OFS_SRC, 32'h8001_0020);
        tick();
        rd(OFS_SRC, v); chk("R4 multi clear", v, 32'h0300_0000);

        // R8: edge arrives with the clear pulse
        port_pins = 32'h0;
        wr(OFS_SRC, 32'hFFFF_FFFF);
        tick();
        port_pins[2] = 1'b1;
        tick();
        port_pins[2] = 1'b0;
        wr(OFS_SRC, 32'h0000_0004);
        port_pins[2] = 1'b1;
        tick();
        rd(OFS_SRC, v); chk("R8 edge beats clear", v, 32'h0000_0004);
        tick();
        rd(OFS_SRC, v); chk("R8 bit holds", v, 32'h0000_0004);
        wr(OFS_SRC, 32'h0000_0004);
        tick();
        rd(OFS_SRC, v); chk("R8 later clear works", v, 32'h0);

        // R7: USB path
        wr(OFS_PIN_EN, 32'h0);
        usb_pin = 1'b1;
        tick();
        rd(OFS_USB_SRC, v); chk("R7 usb rise latched", v, 32'h1);
        chk("R7 usb wakes", {31'b0, wake_req}, 32'h1);
        rd(OFS_SRC, v);     chk("R7 port path untouched", v, 32'h0);
        wr(OFS_USB_SRC, 32'h1);
        tick();
        rd(OFS_USB_SRC, v); chk("R7 usb cleared", v, 32'h0);
        usb_pin = 1'b0;
        tick();
        rd(OFS_USB_SRC, v); chk("R7 usb fall ignored", v, 32'h0);
        wr(OFS_USB_EDGE, 32'h1);
        usb_pin = 1'b1;
        tick();
        usb_pin = 1'b0;
        tick();
        rd(OFS_USB_SRC, v); chk("R7 usb fall latched", v, 32'h1);
        wr(OFS_SRC, 32'hFFFF_FFFF);
        tick();
        rd(OFS_USB_SRC, v); chk("R7 port clear spares usb", v, 32'h1);

        summary();
    end

endmodule